// File: doc/BRIEF.md
# Scaling-Free Micro-Rotation Unit

This unit rotates a fixed-point vector (x, y) by one small, fixed angle. It does not run a long chain of CORDIC iterations. An angle index k picks a short recipe of shift-and-add micro-steps. Each recipe is built so that the vector length is kept without a separate multiply by a gain constant. Small indices mean large angles, and these take more micro-steps. The largest angle, k = 1, takes six cycles, and those six cycles are the per-rotation budget.

All recipes run on one datapath: two adders, two variable arithmetic shifters and a few operand multiplexers. A controller walks the recipe one micro-step per clock. A repeat mode applies the whole recipe several times, so that a short recipe fills the six-cycle budget. Arrays of such units can then advance in lock step. The unit reports completion with a one-cycle `done` pulse and holds the result until the next accepted start.

Top module: `microrot_engine`

## Requirements
- R1: After reset, `done` is 0 and `x_out`, `y_out` are 0.
- R2: For k = 16..32 the unit applies one rotation pair with shift k, computed from the old values: x ← x − σ·(y>>>k), y ← y + σ·(x>>>k). σ is +1 when `ccw`=1 and −1 when `ccw`=0. This is one micro-step.
- R3: For k = 8..15 the unit applies the rotation pair with shift k, then a length correction v ← v − (v>>>(2k+1)) on both coordinates. This is two micro-steps.
- R4: For k = 5..7 the unit applies three shears in this order: x ← x − σ·(y>>>(k+1)), then y ← y + σ·(x>>>k), then x ← x − σ·(y>>>(k+1)). Each shear uses the value just produced.
- R5: For k = 2..4 the unit applies the rotation pair with shift k twice, then v ← v − (v>>>2k), then v ← v + (v>>>4k). This is four micro-steps.
- R6: For k = 1 the unit applies the rotation pair with shift 1 twice, then v ← v − (v>>>2), then v ← v + (v>>>s) for s = 4, 8 and 16 in that order. These six micro-steps are the budget, and no accepted operation stays busy longer than 6 cycles.
- R7: `ccw`=1 turns the vector counter-clockwise: the cross product x_in·y_out − y_in·x_out is positive. `ccw`=0 turns it clockwise.
- R8: With `rep_mode`=1 the full recipe is repeated 6/n times, rounded down, where n is the recipe length. That gives 6 times for k ≥ 16, 3 times for k = 8..15, twice for k = 5..7, and once for k ≤ 4.
- R9: An index of 0 or 33..63 leaves the vector unchanged: `done` pulses on the cycle after start, with `x_out`=`x_in` and `y_out`=`y_in`.
- R10: `done` is a one-cycle pulse that rises in the cycle after the last micro-step, n×repeats cycles after the start edge. The outputs then hold until the next accepted start.
- R11: A `start` that arrives while an operation is running is ignored. The result and the timing of that operation do not change.
- R12: For inputs of magnitude at least 2^20, the output length equals the input length within a relative error of 2^-12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a rotation; sampled only when idle |
| ccw | input | 1 | 1 = counter-clockwise, 0 = clockwise |
| rep_mode | input | 1 | 1 = repeat the recipe to fill the budget |
| k_in | input | 6 | Angle index |
| x_in | input | W | Input x, two's complement |
| y_in | input | W | Input y, two's complement |
| x_out | output | W | Rotated x |
| y_out | output | W | Rotated y |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench covers the edges of every index band: k = 1, 4, 5, 7, 8, 15, 16 and 32. A design that put a boundary index in the wrong recipe gives a result off by many LSBs. It also gives a `done` pulse at the wrong cycle.

Both directions are run, because a swapped sign would still keep the length but turn the vector the wrong way. Negative operands are run at shift 32, where an arithmetic shift yields −1 rather than 0.

Repeat mode is checked against the exact repeat counts. A start pulse in the middle of a k = 1 rotation checks that a careless controller cannot reload its operands. The invalid indices 0, 33 and 63 are checked for a clean pass-through.

// File: rtl/microrot_engine.sv
module microrot_engine #(
  parameter int W      = 32,
  parameter int BUDGET = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                ccw,
  input  logic                rep_mode,
  input  logic [5:0]          k_in,
  input  logic signed [W-1:0] x_in,
  input  logic signed [W-1:0] y_in,
  output logic signed [W-1:0] x_out,
  output logic signed [W-1:0] y_out,
  output logic                done
);
  localparam int CW = $clog2(BUDGET + 1);

  typedef enum logic [1:0] {OP_ROT, OP_SCL, OP_SHX, OP_SHY} op_t;
  typedef struct packed {
    op_t        op;
    logic       neg;
    logic [5:0] sh;
  } uop_t;

  function automatic logic [CW-1:0] steps_of(input logic [5:0] k);
    if (k == 6'd1)                     return CW'(6);
    else if (k >= 6'd2 && k <= 6'd4)   return CW'(4);
    else if (k >= 6'd5 && k <= 6'd7)   return CW'(3);
    else if (k >= 6'd8 && k <= 6'd15)  return CW'(2);
    else if (k >= 6'd16 && k <= 6'd32) return CW'(1);
    else                               return '0;
  endfunction

  function automatic logic [CW-1:0] reps_of(input logic [CW-1:0] n);
    if (n == '0) return CW'(1);
    return CW'(BUDGET / int'(n));
  endfunction

  function automatic uop_t uop_at(input logic [5:0] k, input logic [CW-1:0] s);
    uop_t u;
    u.op  = OP_ROT;
    u.neg = 1'b0;
    u.sh  = k;
    if (k >= 6'd8 && k <= 6'd15) begin
      if (s == CW'(1)) begin
        u.op = OP_SCL; u.neg = 1'b1; u.sh = (k << 1) + 6'd1;
      end
    end else if (k >= 6'd5 && k <= 6'd7) begin
      u.op = (s == CW'(1)) ? OP_SHY : OP_SHX;
      u.sh = (s == CW'(1)) ? k : k + 6'd1;
    end else if (k >= 6'd2 && k <= 6'd4) begin
      if (s == CW'(2)) begin
        u.op = OP_SCL; u.neg = 1'b1; u.sh = k << 1;
      end else if (s == CW'(3)) begin
        u.op = OP_SCL; u.sh = k << 2;
      end
    end else if (k == 6'd1) begin
      if (s >= CW'(2)) begin
        u.op  = OP_SCL;
        u.neg = (s == CW'(2));
        u.sh  = 6'd1 << (s - CW'(1));
      end
    end
    return u;
  endfunction

  logic signed [W-1:0] xr, yr;
  logic [5:0]          kr;
  logic                dr, busy;
  logic [CW-1:0]       stp, rep, nrep;

  wire  [CW-1:0] nst   = steps_of(kr);
  wire  [CW-1:0] n_new = steps_of(k_in);
  wire  uop_t    u     = uop_at(kr, stp);

  wire                scl   = (u.op == OP_SCL);
  wire signed [W-1:0] src_x = scl ? xr : yr;
  wire signed [W-1:0] src_y = scl ? yr : xr;
  wire signed [W-1:0] tx    = src_x >>> u.sh;
  wire signed [W-1:0] ty    = src_y >>> u.sh;
  wire                sub_x = scl ? u.neg : dr;
  wire                sub_y = scl ? u.neg : ~dr;
  wire signed [W-1:0] nx    = sub_x ? xr - tx : xr + tx;
  wire signed [W-1:0] ny    = sub_y ? yr - ty : yr + ty;
  wire                x_en  = (u.op != OP_SHY);
  wire                y_en  = (u.op != OP_SHX);

  assign x_out = xr;
  assign y_out = yr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xr <= '0; yr <= '0; kr <= '0; dr <= 1'b0;
      busy <= 1'b0; done <= 1'b0;
      stp <= '0; rep <= '0; nrep <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          xr   <= x_in;
          yr   <= y_in;
          kr   <= k_in;
          dr   <= ccw;
          stp  <= '0;
          rep  <= CW'(1);
          nrep <= rep_mode ? reps_of(n_new) : CW'(1);
          busy <= (n_new != '0);
          done <= (n_new == '0);
        end
      end else begin
        if (x_en) xr <= nx;
        if (y_en) yr <= ny;
        if (stp == nst - CW'(1)) begin
          stp <= '0;
          if (rep == nrep) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            rep <= rep + CW'(1);
          end
        end else begin
          stp <= stp + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/microrot_engine_chk.sv
module microrot_engine_chk #(
  parameter int W      = 32,
  parameter int BUDGET = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                rep_mode,
  input logic                busy,
  input logic [5:0]          k_in,
  input logic signed [W-1:0] x_in,
  input logic signed [W-1:0] y_in,
  input logic signed [W-1:0] x_out,
  input logic signed [W-1:0] y_out,
  input logic                done
);
  logic [7:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (start && !busy)   cnt <= '0;
    else if (busy)             cnt <= cnt + 8'd1;
  end

  assert_budget_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < 8'(BUDGET)));

  assert_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (k_in == 6'd0 || k_in > 6'd32))
      |=> (done && x_out == $past(x_in) && y_out == $past(y_in)));

  assert_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !rep_mode && k_in >= 6'd16 && k_in <= 6'd32)
      |=> (!done ##1 done));

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(x_out) && $stable(y_out)));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind microrot_engine microrot_engine_chk #(.W(W), .BUDGET(BUDGET)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rep_mode(rep_mode), .busy(busy),
  .k_in(k_in), .x_in(x_in), .y_in(y_in), .x_out(x_out), .y_out(y_out),
  .done(done)
);

// File: tb/microrot_engine_test.sv
module microrot_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, ccw = 1'b0, rep_mode = 1'b0;
  logic [5:0] k_in = '0;
  logic signed [31:0] x_in = '0, y_in = '0;
  logic signed [31:0] x_out, y_out;
  logic done;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  microrot_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ccw(ccw), .rep_mode(rep_mode),
    .k_in(k_in), .x_in(x_in), .y_in(y_in), .x_out(x_out), .y_out(y_out),
    .done(done)
  );

  function automatic longint w32(input longint v);
    logic signed [31:0] t;
    t = v[31:0];
    return longint'(t);
  endfunction

  function automatic void rot(inout longint x, inout longint y, input int s, input bit d);
    longint ox = x, oy = y;
    x = d ? w32(ox - (oy >>> s)) : w32(ox + (oy >>> s));
    y = d ? w32(oy + (ox >>> s)) : w32(oy - (ox >>> s));
  endfunction

  function automatic void scl(inout longint x, inout longint y, input int s, input bit neg);
    x = neg ? w32(x - (x >>> s)) : w32(x + (x >>> s));
    y = neg ? w32(y - (y >>> s)) : w32(y + (y >>> s));
  endfunction

  function automatic int len_of(input int k);
    if (k == 1) return 6;
    if (k >= 2 && k <= 4) return 4;
    if (k >= 5 && k <= 7) return 3;
    if (k >= 8 && k <= 15) return 2;
    if (k >= 16 && k <= 32) return 1;
    return 0;
  endfunction

  function automatic void mdl(input longint xi, input longint yi, input int k, input bit d,
                              input bit rp, output longint xo, output longint yo, output int lat);
    longint x = xi, y = yi;
    int n = len_of(k);
    int reps = (rp && n != 0) ? 6 / n : 1;
    lat = n * reps;
    for (int r = 0; r < reps && n != 0; r++) begin
      if (k >= 16) rot(x, y, k, d);
      else if (k >= 8) begin rot(x, y, k, d); scl(x, y, 2*k + 1, 1'b1); end
      else if (k >= 5) begin
        x = d ? w32(x - (y >>> (k+1))) : w32(x + (y >>> (k+1)));
        y = d ? w32(y + (x >>> k))     : w32(y - (x >>> k));
        x = d ? w32(x - (y >>> (k+1))) : w32(x + (y >>> (k+1)));
      end else if (k >= 2) begin
        rot(x, y, k, d); rot(x, y, k, d);
        scl(x, y, 2*k, 1'b1); scl(x, y, 4*k, 1'b0);
      end else begin
        rot(x, y, 1, d); rot(x, y, 1, d);
        scl(x, y, 2, 1'b1); scl(x, y, 4, 1'b0); scl(x, y, 8, 1'b0); scl(x, y, 16, 1'b0);
      end
    end
    xo = x; yo = y;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run(input longint xa, input longint ya, input int k, input bit d,
                     input bit rp, input string req);
    longint ex, ey;
    int lat;
    real ri, ro, cr;
    mdl(xa, ya, k, d, rp, ex, ey, lat);
    @(negedge clk);
    x_in = xa[31:0]; y_in = ya[31:0]; k_in = 6'(k); ccw = d; rep_mode = rp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n <= lat; n++) begin
      if (n > 0) @(negedge clk);
      chk(done == (n == lat), req, "done timing", longint'(done), longint'(n == lat));
    end
    chk(longint'(x_out) == ex, req, "x_out", longint'(x_out), ex);
    chk(longint'(y_out) == ey, req, "y_out", longint'(y_out), ey);
    @(negedge clk);
    chk(!done, "R10", "done pulse width", longint'(done), 0);
    chk(longint'(x_out) == ex && longint'(y_out) == ey, "R10", "hold x", longint'(x_out), ex);
    if (lat != 0) begin
      ri = $sqrt(real'(xa)*real'(xa) + real'(ya)*real'(ya));
      ro = $sqrt(real'(x_out)*real'(x_out) + real'(y_out)*real'(y_out));
      chk((ro/ri - 1.0 < 2.0**-12) && (1.0 - ro/ri < 2.0**-12), "R12", "norm ppm",
          longint'((ro/ri - 1.0) * 1.0e6), 0);
      cr = real'(xa)*real'(y_out) - real'(ya)*real'(x_out);
      chk(d ? (cr > 0.0) : (cr < 0.0), "R7", "rotation sense", longint'(cr > 0.0), longint'(d));
    end
  endtask

  initial begin
    #800000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint ex, ey;
    int lat;
    repeat (3) @(negedge clk);
    chk(!done, "R1", "reset done", longint'(done), 0);
    chk(x_out == 0 && y_out == 0, "R1", "reset x_out", longint'(x_out), 0);
    rst_n = 1'b1;

    run(64'sd16777216,  64'sd3145728,   20, 1'b1, 1'b0, "R2");
    run(-64'sd9000000,  64'sd5000000,   16, 1'b0, 1'b0, "R2");
    run(-64'sd12345678, -64'sd7654321,  32, 1'b1, 1'b0, "R2");
    run(64'sd20000000,  -64'sd1500000,   8, 1'b1, 1'b0, "R3");
    run(-64'sd4000000,  64'sd30000000,  15, 1'b0, 1'b0, "R3");
    run(64'sd10000000,  64'sd10000000,   5, 1'b1, 1'b0, "R4");
    run(64'sd7000000,   -64'sd22000000,  7, 1'b0, 1'b0, "R4");
    run(64'sd8000000,   64'sd2000000,    2, 1'b1, 1'b0, "R5");
    run(-64'sd6000000,  64'sd9000000,    3, 1'b0, 1'b0, "R5");
    run(64'sd11000000,  -64'sd3000000,   4, 1'b1, 1'b0, "R5");
    run(64'sd20000000,  64'sd0,          1, 1'b1, 1'b0, "R6");
    run(-64'sd5000000,  -64'sd15000000,  1, 1'b0, 1'b0, "R6");
    run(64'sd16777216,  64'sd1048576,   20, 1'b1, 1'b1, "R8");
    run(64'sd9000000,   -64'sd9000000,   8, 1'b0, 1'b1, "R8");
    run(64'sd3000000,   64'sd12000000,   5, 1'b1, 1'b1, "R8");
    run(64'sd10000000,  64'sd4000000,    3, 1'b1, 1'b1, "R8");
    run(64'sd10000000,  64'sd4000000,    1, 1'b0, 1'b1, "R8");
    run(64'sd1234567,   -64'sd7654321,   0, 1'b1, 1'b0, "R9");
    run(-64'sd42,       64'sd99,        33, 1'b0, 1'b1, "R9");
    run(64'sd2147483647, -64'sd2147483648, 63, 1'b1, 1'b0, "R9");

    mdl(64'sd12000000, 64'sd6000000, 1, 1'b1, 1'b0, ex, ey, lat);
    @(negedge clk);
    x_in = 32'sd12000000; y_in = 32'sd6000000; k_in = 6'd1; ccw = 1'b1; rep_mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n <= lat; n++) begin
      if (n > 0) @(negedge clk);
      if (n == 2) begin
        x_in = -32'sd777; y_in = 32'sd555; k_in = 6'd20; ccw = 1'b0; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      chk(done == (n == lat), "R11", "done timing", longint'(done), longint'(n == lat));
    end
    start = 1'b0;
    chk(longint'(x_out) == ex, "R11", "x_out", longint'(x_out), ex);
    chk(longint'(y_out) == ey, "R11", "y_out", longint'(y_out), ey);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule